// File: doc/BRIEF.md
# Multi-Mode Reloadable Down-Counter Timer

This block is an 8-bit down-counter with a reload latch. One counter core serves four modes, chosen by a 2-bit mode field. In the interval mode it counts a divide-by-16 clock enable. In the square-wave mode it counts the same enable and drives a counter pin that flips on every wrap. In the event mode it counts edges seen on the counter pin. In the width mode it counts the enable only while the pin sits at a chosen level. The counter wraps from 0x00 to the latch value, so a latch value of n gives one wrap every n+1 count pulses. Each wrap raises a sticky timer interrupt flag.

A single polarity bit changes meaning with the mode. It selects which pin edge raises the pin interrupt flag, which edge is counted in the event mode, the starting level of the square wave, and the pin level during which the width mode counts. A halt bit freezes counting in every mode. Software loads the latch through a data write strobe. That write also loads the counter when the timer is halted, and otherwise takes effect at the next wrap. The pin input passes through a synchronizer before its level and edges are used.

Top module: `mode_timer`

## Requirements
- R1: Each count pulse decrements the counter by one. A count pulse that finds the counter at 0x00 reloads it from the latch instead; this is a wrap.
- R2: With latch value n (0..255), wraps occur exactly every n+1 count pulses.
- R3: In mode 2'b00 the count pulse is `tick16`. The counter does not change in cycles without `tick16`.
- R4: In mode 2'b01 the count pulse is `tick16`. Any control write sets `pin_out` to 1 when `ctrl_pol` is 0 and to 0 when it is 1. `pin_out` inverts on every wrap in this mode. `pin_oe` is 1 only while the mode is 2'b01.
- R5: In mode 2'b10 the counter counts rising edges of the synchronized pin when the polarity bit is 0 and falling edges when it is 1. `tick16` has no effect in this mode.
- R6: In mode 2'b11 a `tick16` pulse counts only while the synchronized pin is high (polarity 0) or low (polarity 1).
- R7: While the halt bit is 1, the counter does not change in any mode, except through a data write.
- R8: A wrap sets `irq_tmr`. The flag stays set until an `irq_tmr_clr` pulse, and a wrap takes priority over a clear in the same cycle.
- R9: `irq_pin` is set by a falling pin edge when the polarity bit is 0 and by a rising edge when it is 1. The opposite edge does not set it. It stays set until an `irq_pin_clr` pulse.
- R10: A data write while halted loads both the latch and the counter. A data write while running changes only the latch, and the counter picks up the new value at the next wrap.
- R11: After reset the counter and the latch read 0xFF, the mode is 2'b00, the polarity bit is 0, the halt bit is 1, `pin_out` is 1, and `pin_oe`, `irq_tmr` and `irq_pin` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Divide-by-16 count enable, one cycle wide |
| pin_in | input | 1 | Counter pin input (asynchronous) |
| dat_wr | input | 1 | Data write strobe (latch, and counter when halted) |
| dat_val | input | 8 | Data write value |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_mode | input | 2 | Mode: 00 interval, 01 square wave, 10 event, 11 width |
| ctrl_pol | input | 1 | Polarity bit |
| ctrl_halt | input | 1 | Halt bit, 1 stops counting |
| irq_tmr_clr | input | 1 | Clears the timer interrupt flag |
| irq_pin_clr | input | 1 | Clears the pin interrupt flag |
| cnt_val | output | 8 | Current counter contents |
| pin_out | output | 1 | Counter pin output value |
| pin_oe | output | 1 | Counter pin output enable |
| irq_tmr | output | 1 | Timer interrupt request flag |
| irq_pin | output | 1 | Pin edge interrupt request flag |

## Verification
A wrong counter value shows on `cnt_val` one cycle after the count pulse that caused it. The bench compares the counter after every pulse, so a bad decrement or reload is seen in that same cycle. A wrong count source or pin polarity shows as a missing or extra decrement three cycles after the pin change, once the synchronizer and edge register have passed it on. A latch that holds the wrong value hides until the next wrap, which is why each sweep runs at least two full periods and writes the latch while the timer runs.

// File: rtl/mode_timer_pkg.sv
package mode_timer_pkg;

    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'b00,
        MODE_SQUARE   = 2'b01,
        MODE_EVENT    = 2'b10,
        MODE_WIDTH    = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e mode;
        logic      pol;
        logic      halt;
    } tmr_ctrl_t;

    localparam tmr_ctrl_t CTRL_RESET = '{mode: MODE_INTERVAL, pol: 1'b0, halt: 1'b1};

    // Count pulse source chosen by the mode; polarity flips its meaning per mode.
    function automatic logic count_source(
        input tmr_mode_e m,
        input logic      pol,
        input logic      tick,
        input logic      rise,
        input logic      fall,
        input logic      lvl
    );
        logic r;
        case (m)
            MODE_INTERVAL: r = tick;
            MODE_SQUARE:   r = tick;
            MODE_EVENT:    r = pol ? fall : rise;
            MODE_WIDTH:    r = tick & (lvl ^ pol);
            default:       r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    output logic pin_lvl,
    output logic pin_rise,
    output logic pin_fall
);
    logic [STAGES-1:0] stage_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= 1'b0;
                    else     stage_q[0] <= pin_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= 1'b0;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= stage_q[STAGES-1];
    end

    assign pin_lvl  = stage_q[STAGES-1];
    assign pin_rise = stage_q[STAGES-1] & ~prev_q;
    assign pin_fall = ~stage_q[STAGES-1] & prev_q;

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         halted,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] cnt_q,
    output logic         wrap
);
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ZERO     = '0;
    localparam logic [W-1:0] ONE      = W'(1);

    logic [W-1:0] latch_q;

    assign wrap = cnt_en && (cnt_q == ZERO);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= ALL_ONES;
            cnt_q   <= ALL_ONES;
        end else begin
            if (wr_en) latch_q <= wr_val;
            if (wr_en && halted)  cnt_q <= wr_val;
            else if (cnt_en)      cnt_q <= (cnt_q == ZERO) ? latch_q : cnt_q - ONE;
        end
    end

    AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && cnt_q == ZERO) |=> (cnt_q == $past(latch_q)));          // R1
    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - ONE));      // R1
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (halted && !wr_en) |=> $stable(cnt_q));                           // R7
    AST_RUN_WRITE_LATCH_ONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !halted && !cnt_en) |=> $stable(cnt_q));                // R10

endmodule

// File: rtl/tmr_pulse_out.sv
module tmr_pulse_out (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic load_lvl,
    input  logic toggle,
    output logic out_q
);
    always_ff @(posedge clk) begin
        if (rst)         out_q <= 1'b1;
        else if (load)   out_q <= load_lvl;
        else if (toggle) out_q <= ~out_q;
    end
endmodule

// File: rtl/mode_timer.sv
module mode_timer
    import mode_timer_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick16,
    input  logic             pin_in,
    input  logic             dat_wr,
    input  logic [CNT_W-1:0] dat_val,
    input  logic             ctrl_wr,
    input  logic [1:0]       ctrl_mode,
    input  logic             ctrl_pol,
    input  logic             ctrl_halt,
    input  logic             irq_tmr_clr,
    input  logic             irq_pin_clr,
    output logic [CNT_W-1:0] cnt_val,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             irq_tmr,
    output logic             irq_pin
);
    tmr_ctrl_t ctrl_q;
    logic      pin_lvl, pin_rise, pin_fall;
    logic      cnt_en, wrap, pin_evt;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= CTRL_RESET;
        else if (ctrl_wr) ctrl_q <= '{mode: tmr_mode_e'(ctrl_mode), pol: ctrl_pol, halt: ctrl_halt};
    end

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .pin_raw  (pin_in),
        .pin_lvl  (pin_lvl),
        .pin_rise (pin_rise),
        .pin_fall (pin_fall)
    );

    assign cnt_en = !ctrl_q.halt &&
                    count_source(ctrl_q.mode, ctrl_q.pol, tick16, pin_rise, pin_fall, pin_lvl);

    tmr_count_core #(.W(CNT_W)) core_i (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .halted (ctrl_q.halt),
        .wr_en  (dat_wr),
        .wr_val (dat_val),
        .cnt_q  (cnt_val),
        .wrap   (wrap)
    );

    tmr_pulse_out pout_i (
        .clk      (clk),
        .rst      (rst),
        .load     (ctrl_wr),
        .load_lvl (~ctrl_pol),
        .toggle   (wrap && ctrl_q.mode == MODE_SQUARE),
        .out_q    (pin_out)
    );

    assign pin_oe  = (ctrl_q.mode == MODE_SQUARE);
    assign pin_evt = ctrl_q.pol ? pin_rise : pin_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_tmr <= 1'b0;
            irq_pin <= 1'b0;
        end else begin
            if (wrap)             irq_tmr <= 1'b1;
            else if (irq_tmr_clr) irq_tmr <= 1'b0;
            if (pin_evt)          irq_pin <= 1'b1;
            else if (irq_pin_clr) irq_pin <= 1'b0;
        end
    end

    AST_WRAP_SETS_IRQ: assert property (@(posedge clk) disable iff (rst)
        wrap |=> irq_tmr);                                                 // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_tmr && !irq_tmr_clr) |=> irq_tmr);                            // R8
    AST_PIN_EDGE_IRQ: assert property (@(posedge clk) disable iff (rst)
        pin_evt |=> irq_pin);                                              // R9
    AST_SQUARE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (wrap && ctrl_q.mode == MODE_SQUARE && !ctrl_wr) |=> (pin_out != $past(pin_out))); // R4
    AST_EVENT_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode == MODE_EVENT && !pin_rise && !pin_fall && !dat_wr) |=> $stable(cnt_val)); // R5

endmodule

// File: tb/mode_timer_tb_top.sv
module mode_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0, pin_in = 1'b0;
    logic       dat_wr = 1'b0, ctrl_wr = 1'b0;
    logic [7:0] dat_val = 8'h00;
    logic [1:0] ctrl_mode = 2'b00;
    logic       ctrl_pol = 1'b0, ctrl_halt = 1'b1;
    logic       irq_tmr_clr = 1'b0, irq_pin_clr = 1'b0;
    logic [7:0] cnt_val;
    logic       pin_out, pin_oe, irq_tmr, irq_pin;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    logic exp_out;

    always #5 clk = ~clk;

    mode_timer dut_i (
        .clk(clk), .rst(rst), .tick16(tick16), .pin_in(pin_in),
        .dat_wr(dat_wr), .dat_val(dat_val), .ctrl_wr(ctrl_wr),
        .ctrl_mode(ctrl_mode), .ctrl_pol(ctrl_pol), .ctrl_halt(ctrl_halt),
        .irq_tmr_clr(irq_tmr_clr), .irq_pin_clr(irq_pin_clr),
        .cnt_val(cnt_val), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_tmr(irq_tmr), .irq_pin(irq_pin)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [1:0] m, input logic p, input logic h);
        ctrl_mode = m; ctrl_pol = p; ctrl_halt = h; ctrl_wr = 1'b1;
        cyc();
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] v);
        dat_val = v; dat_wr = 1'b1;
        cyc();
        dat_wr = 1'b0;
    endtask

    task automatic clr_tmr();
        irq_tmr_clr = 1'b1; cyc(); irq_tmr_clr = 1'b0;
    endtask

    task automatic clr_pin();
        irq_pin_clr = 1'b1; cyc(); irq_pin_clr = 1'b0;
    endtask

    task automatic one_tick();
        tick16 = 1'b1; cyc(); tick16 = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        pin_in = v;
        repeat (4) cyc();
    endtask

    // Counter holds n, latch holds n, running: step through whole periods.
    task automatic run_periods(input int n, input int periods, input bit sq);
        for (int p = 0; p < periods; p++) begin
            for (int k = 1; k <= n + 1; k++) begin
                one_tick();
                chk("R1 count value", cnt_val, (k <= n) ? n - k : n);
                chk("R2 wrap spacing", irq_tmr, (k == n + 1));
                if (sq) begin
                    if (k == n + 1) exp_out = ~exp_out;
                    chk("R4 square level", pin_out, exp_out);
                end
                cyc();
                chk("R3 no tick no count", cnt_val, (k <= n) ? n - k : n);
            end
            chk("R8 flag held", irq_tmr, 1);
            clr_tmr();
            chk("R8 flag cleared", irq_tmr, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) cyc();
        rst = 1'b0;
        cyc();
        // R11 reset state
        chk("R11 counter", cnt_val, 255);
        chk("R11 pin_out", pin_out, 1);
        chk("R11 pin_oe", pin_oe, 0);
        chk("R11 irq_tmr", irq_tmr, 0);
        chk("R11 irq_pin", irq_pin, 0);
        one_tick();
        chk("R11 halted after reset", cnt_val, 255);
        // R11 latch 0xFF: run from reset contents
        wr_ctrl(2'b00, 1'b0, 1'b0);
        run_periods(255, 1, 0);

        // R1 R2 R3 sweep of latch values
        for (int n = 0; n < 17; n++) begin
            automatic int nv = (n == 16) ? 200 : n;
            wr_ctrl(2'b00, 1'b0, 1'b1);
            wr_dat(nv[7:0]);
            chk("R10 halted write loads counter", cnt_val, nv);
            wr_ctrl(2'b00, 1'b0, 1'b0);
            clr_tmr();
            run_periods(nv, 2, 0);
        end

        // R4 square wave, both polarities
        for (int pp = 0; pp < 2; pp++) begin
            wr_ctrl(2'b01, pp[0], 1'b1);
            chk("R4 start level", pin_out, !pp[0]);
            chk("R4 oe in square mode", pin_oe, 1);
            wr_dat(8'd3);
            wr_ctrl(2'b01, pp[0], 1'b0);
            exp_out = !pp[0];
            chk("R4 start level after run", pin_out, exp_out);
            run_periods(3, 3, 1);
        end
        wr_ctrl(2'b00, 1'b0, 1'b1);
        chk("R4 oe off outside square", pin_oe, 0);

        // R10 running write touches only the latch
        wr_dat(8'd5);
        wr_ctrl(2'b00, 1'b0, 1'b0);
        one_tick(); one_tick();
        chk("R10 before write", cnt_val, 3);
        wr_dat(8'd9);
        chk("R10 running write keeps counter", cnt_val, 3);
        repeat (3) one_tick();
        chk("R10 reached zero", cnt_val, 0);
        one_tick();
        chk("R10 new latch on wrap", cnt_val, 9);
        chk("R8 wrap sets flag", irq_tmr, 1);
        cyc(); cyc();
        chk("R8 flag sticky", irq_tmr, 1);
        clr_tmr();
        run_periods(9, 1, 0);

        // R7 halt in interval mode
        one_tick();
        chk("R7 running step", cnt_val, 8);
        wr_ctrl(2'b00, 1'b0, 1'b1);
        repeat (10) one_tick();
        chk("R7 halt interval", cnt_val, 8);

        // R5 event counting, polarity 0: rising edges
        wr_dat(8'd4);
        wr_ctrl(2'b10, 1'b0, 1'b0);
        tick16 = 1'b1;
        for (int e = 1; e <= 5; e++) begin
            set_pin(1'b1);
            chk("R5 rising edge counted", cnt_val, (e <= 4) ? 4 - e : 4);
            chk("R9 rise ignored pol0", irq_pin, 0);
            set_pin(1'b0);
            chk("R5 falling edge ignored", cnt_val, (e <= 4) ? 4 - e : 4);
            chk("R9 fall sets pol0", irq_pin, 1);
            clr_pin();
            chk("R9 cleared", irq_pin, 0);
        end
        chk("R5 wrap on fifth edge", irq_tmr, 1);
        clr_tmr();
        // polarity 1: falling edges
        wr_ctrl(2'b10, 1'b1, 1'b0);
        for (int e = 1; e <= 3; e++) begin
            set_pin(1'b1);
            chk("R5 rising ignored pol1", cnt_val, 5 - e);
            chk("R9 rise sets pol1", irq_pin, 1);
            clr_pin();
            set_pin(1'b0);
            chk("R5 falling counted pol1", cnt_val, 4 - e);
            chk("R9 fall ignored pol1", irq_pin, 0);
        end
        // R7 halt in event mode
        wr_ctrl(2'b10, 1'b1, 1'b1);
        set_pin(1'b1); set_pin(1'b0);
        chk("R7 halt event", cnt_val, 1);
        tick16 = 1'b0;
        clr_pin();

        // R6 width measurement
        wr_dat(8'd20);
        wr_ctrl(2'b11, 1'b0, 1'b0);
        set_pin(1'b1);
        chk("R6 no count without tick", cnt_val, 20);
        repeat (5) one_tick();
        chk("R6 counts while high pol0", cnt_val, 15);
        set_pin(1'b0);
        repeat (5) one_tick();
        chk("R6 idle while low pol0", cnt_val, 15);
        wr_ctrl(2'b11, 1'b1, 1'b0);
        repeat (5) one_tick();
        chk("R6 counts while low pol1", cnt_val, 10);
        set_pin(1'b1);
        repeat (5) one_tick();
        chk("R6 idle while high pol1", cnt_val, 10);
        wr_ctrl(2'b11, 1'b1, 1'b1);
        repeat (5) one_tick();
        chk("R7 halt width", cnt_val, 10);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule